// File: doc/BRIEF.md
# RTC Smooth Drift Calibration Unit

This block trims the long-term rate of a real-time clock. It sits between the oscillator sampler, which produces one strobe per RTC clock period, and the prescaler chain. In most periods it passes the strobe straight through as a corrected tick. Across a calibration window of 8, 16 or 32 seconds, it can also suppress a programmed number of ticks and insert extra ticks. The net change per window is the add flag times 2^MASK_W, minus the mask count. The dropped and inserted ticks are spread evenly through the window, so the short-term jitter stays at one tick.

Software programs a window length, an add flag and a mask count through a one-cycle write strobe. The new setting is held in a shadow stage and a pending flag is raised. The setting only becomes active at the next window boundary, so a window is never split between two settings. The window counter counts strobes. With the default 20-bit counter, a 32-second window is 2^20 strobes of a 32.768 kHz source. Each count of the mask is worth about 0.95 ppm.

Top module: `rtc_smooth_cal`

## Requirements
- R1: After reset the active setting is the 32-second window with no add and a mask of 0. The pending flag is 0, and every strobe produces exactly one tick and no other tick appears.
- R2: The window is 2^CNT_W strobes long when both select bits are 0, half that when only the 16-second select is 1, and a quarter when the 8-second select is 1. The 8-second select wins over the 16-second select.
- R3: In the 32-second window, a mask count of m (0 to 2^MASK_W−1) suppresses exactly m strobes per window.
- R4: With the add flag set, one extra tick is inserted for each slot strobe. A slot strobe is one where the low CNT_W−MASK_W counter bits are zero, which gives 2^MASK_W >> s inserted ticks per window for a window shift s of 0, 1 or 2. The extra tick appears in the first following clock cycle that has no strobe.
- R5: The ticks per window are (2^CNT_W >> s) + add·(2^MASK_W >> s) − (mask >> s).
- R6: In the 16-second window the lowest mask bit has no effect, and in the 8-second window the lowest two mask bits have no effect.
- R7: Suppressed strobes are always slot strobes, at most one per slot. The slot with index j is suppressed when the bit-reversed j (MASK_W bits) is below the effective mask. For example, a mask of 2 in the 32-second window suppresses the first strobe and the strobe at the window midpoint.
- R8: A write raises the pending flag in the next cycle and leaves the active setting unchanged. At the next window boundary the shadow becomes active for the following window and the flag clears, unless another write comes in that same cycle.
- R9: A tick in a cycle without a strobe occurs only as an inserted tick. With the add flag clear, no such tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rtc_en_i | input | 1 | One-cycle strobe per RTC clock period; at least one idle cycle follows each strobe |
| cfg_wr_i | input | 1 | Write strobe for the calibration setting |
| cfg_sel8_i | input | 1 | Select 8-second window |
| cfg_sel16_i | input | 1 | Select 16-second window |
| cfg_add_i | input | 1 | Insert 2^MASK_W ticks per 32-second span |
| cfg_mask_i | input | MASK_W | Number of strobes to suppress per 32-second span |
| tick_o | output | 1 | Corrected tick enable to the prescaler |
| pend_o | output | 1 | A written setting is waiting for the window boundary |

## Verification
The tick count over a whole window is compared with the net formula for pass-through, masking only, adding with a zero mask, and adding with the largest mask. Together these separate the insertion path from the suppression path and expose an off-by-one in the comparison. The 16- and 8-second settings are run with odd mask values and compared against even ones. This shows that the low mask bits are truncated and that the 8-second select takes priority. A mask of 2 shows where the suppressed strobes fall, which tells bit-reversed spreading apart from a plain ascending order. A write early in a window checks that the old setting governs that whole window, and that the pending flag drops only at the boundary.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [1:0] {
    WIN_32 = 2'd0,
    WIN_16 = 2'd1,
    WIN_8  = 2'd2
  } win_e;

  // 8-second select has priority over 16-second select
  function automatic win_e win_decode(input logic sel8, input logic sel16);
    if (sel8)       return WIN_8;
    else if (sel16) return WIN_16;
    else            return WIN_32;
  endfunction

  // number of halvings applied to the longest window
  function automatic logic [1:0] win_shift(input win_e w);
    case (w)
      WIN_16:  return 2'd1;
      WIN_8:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_cfg.sv
module rtc_cal_cfg
  import rtc_cal_pkg::*;
#(
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel8_i,
  input  logic              sel16_i,
  input  logic              add_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              win_end_i,
  output win_e              act_win_o,
  output logic              act_add_o,
  output logic [MASK_W-1:0] act_mask_o,
  output logic              pend_o
);

  win_e              sh_win_q;
  logic              sh_add_q;
  logic [MASK_W-1:0] sh_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_win_q   <= WIN_32;
      sh_add_q   <= 1'b0;
      sh_mask_q  <= '0;
      act_win_o  <= WIN_32;
      act_add_o  <= 1'b0;
      act_mask_o <= '0;
      pend_o     <= 1'b0;
    end else begin
      if (win_end_i) begin
        act_win_o  <= sh_win_q;
        act_add_o  <= sh_add_q;
        act_mask_o <= sh_mask_q;
      end
      if (wr_i) begin
        sh_win_q  <= win_decode(sel8_i, sel16_i);
        sh_add_q  <= add_i;
        sh_mask_q <= mask_i;
        pend_o    <= 1'b1;
      end else if (win_end_i) begin
        pend_o    <= 1'b0;
      end
    end
  end

  p_wr_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_o);

  p_pend_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && !wr_i) |=> !pend_o);

  p_hold_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> ($stable(act_win_o) && $stable(act_add_o) && $stable(act_mask_o)));

endmodule

// File: rtl/rtc_cal_window.sv
module rtc_cal_window
  import rtc_cal_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_en_i,
  input  win_e              win_i,
  output logic              slot_o,
  output logic [MASK_W-1:0] seg_o,
  output logic              win_end_o
);

  localparam int SEG_LO = CNT_W - MASK_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = {CNT_W{1'b1}} >> win_shift(win_i);
  assign win_end_o = rtc_en_i && (cnt_q == last);
  assign slot_o    = rtc_en_i && (cnt_q[SEG_LO-1:0] == '0);
  assign seg_o     = cnt_q[CNT_W-1 -: MASK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (rtc_en_i)    cnt_q <= win_end_o ? '0 : cnt_q + CNT_W'(1);
  end

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtc_en_i |=> $stable(cnt_q));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (cnt_q == '0));

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);

endmodule

// File: rtl/rtc_cal_pulse.sv
module rtc_cal_pulse
  import rtc_cal_pkg::*;
#(
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_en_i,
  input  logic              slot_i,
  input  logic [MASK_W-1:0] seg_i,
  input  win_e              win_i,
  input  logic              add_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              tick_o
);

  logic [MASK_W-1:0] seg_rev;
  logic [MASK_W-1:0] keep;
  logic [MASK_W-1:0] mask_eff;
  logic              drop;
  logic              ins_q;

  for (genvar i = 0; i < MASK_W; i++) begin : g_rev
    assign seg_rev[i] = seg_i[MASK_W-1-i];
  end

  assign keep     = {MASK_W{1'b1}} << win_shift(win_i);
  assign mask_eff = mask_i & keep;
  assign drop     = slot_i && (seg_rev < mask_eff);
  assign tick_o   = rtc_en_i ? !drop : ins_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ins_q <= 1'b0;
    else if (rtc_en_i) ins_q <= ins_q || (slot_i && add_i);
    else               ins_q <= 1'b0;
  end

  p_drop_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |-> slot_i);

  p_ins_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && add_i) |=> ins_q);

  p_idle_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !rtc_en_i) |-> $past(rtc_en_i));

endmodule

// File: rtl/rtc_smooth_cal.sv
module rtc_smooth_cal
  import rtc_cal_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_en_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel8_i,
  input  logic              cfg_sel16_i,
  input  logic              cfg_add_i,
  input  logic [MASK_W-1:0] cfg_mask_i,
  output logic              tick_o,
  output logic              pend_o
);

  win_e              act_win;
  logic              act_add;
  logic [MASK_W-1:0] act_mask;
  logic              slot;
  logic [MASK_W-1:0] seg;
  logic              win_end;

  rtc_cal_cfg #(.MASK_W(MASK_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .sel8_i     (cfg_sel8_i),
    .sel16_i    (cfg_sel16_i),
    .add_i      (cfg_add_i),
    .mask_i     (cfg_mask_i),
    .win_end_i  (win_end),
    .act_win_o  (act_win),
    .act_add_o  (act_add),
    .act_mask_o (act_mask),
    .pend_o     (pend_o)
  );

  rtc_cal_window #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rtc_en_i  (rtc_en_i),
    .win_i     (act_win),
    .slot_o    (slot),
    .seg_o     (seg),
    .win_end_o (win_end)
  );

  rtc_cal_pulse #(.MASK_W(MASK_W)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rtc_en_i (rtc_en_i),
    .slot_i   (slot),
    .seg_i    (seg),
    .win_i    (act_win),
    .add_i    (act_add),
    .mask_i   (act_mask),
    .tick_o   (tick_o)
  );

  p_tick_on_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtc_en_i && !slot) |-> tick_o);

endmodule

// File: tb/rtc_smooth_cal_test.sv
module rtc_smooth_cal_test;

  localparam int CW = 11;
  localparam int MW = 9;
  localparam int WLEN = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rtc_en = 1'b0;
  logic          cfg_wr = 1'b0;
  logic          cfg_s8 = 1'b0;
  logic          cfg_s16 = 1'b0;
  logic          cfg_add = 1'b0;
  logic [MW-1:0] cfg_mask = '0;
  logic          tick;
  logic          pend;

  rtc_smooth_cal #(.CNT_W(CW), .MASK_W(MW)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rtc_en_i    (rtc_en),
    .cfg_wr_i    (cfg_wr),
    .cfg_sel8_i  (cfg_s8),
    .cfg_sel16_i (cfg_s16),
    .cfg_add_i   (cfg_add),
    .cfg_mask_i  (cfg_mask),
    .tick_o      (tick),
    .pend_o      (pend)
  );

  always #2 clk = ~clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  run = 0;
  bit  done = 0;
  int  gt = 0;
  int  m_lo = -10, m_hi = -10;
  int  ocnt, lowcnt, dropcnt, drop0, drop1;
  int  mon_idx;

  // strobe every other cycle while running
  initial forever begin
    @(posedge clk);
    #1 rtc_en = run ? ~rtc_en : 1'b0;
  end

  // monitor: attribute each cycle to the most recent strobe index
  always @(negedge clk) begin
    if (!rst_n) gt = 0;
    else begin
      mon_idx = rtc_en ? gt : gt - 1;
      if (mon_idx >= m_lo && mon_idx < m_hi) begin
        if (tick) ocnt++;
        if (!rtc_en && tick) lowcnt++;
        if (rtc_en && !tick) begin
          if (dropcnt == 0) drop0 = mon_idx - m_lo;
          else if (dropcnt == 1) drop1 = mon_idx - m_lo;
          dropcnt++;
        end
      end
      if (rtc_en) gt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_net(input int k, input bit add, input int mask);
    int len = WLEN;
    int ins = add ? (1 << MW) : 0;
    int msk = mask;
    for (int i = 0; i < k; i++) begin
      len = len / 2;
      ins = ins / 2;
      msk = msk / 2;
    end
    return len + ins - msk;
  endfunction

  task automatic set_range(input int lo, input int len);
    m_lo = lo; m_hi = lo + len;
    ocnt = 0; lowcnt = 0; dropcnt = 0; drop0 = -1; drop1 = -1;
  endtask

  task automatic wait_gt(input int n);
    while (gt < n) @(posedge clk);
  endtask

  task automatic do_reset;
    run = 0;
    cfg_wr = 0;
    rst_n = 0;
    m_lo = -10; m_hi = -10;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    run = 1;
  endtask

  task automatic cfg_write(input bit s8, input bit s16, input bit add, input int mask);
    @(posedge clk);
    #1;
    cfg_s8 = s8; cfg_s16 = s16; cfg_add = add; cfg_mask = MW'(mask);
    cfg_wr = 1;
    @(posedge clk);
    #1 cfg_wr = 0;
  endtask

  // one setting written in window 0, measured over window 1
  task automatic run_case(input string tag, input bit s8, input bit s16,
                          input bit add, input int mask);
    int k = s8 ? 2 : (s16 ? 1 : 0);
    int len = WLEN >> k;
    do_reset;
    set_range(WLEN, len);
    wait_gt(10);
    cfg_write(s8, s16, add, mask);
    wait_gt(m_hi + 1);
    @(negedge clk);
    chk({tag, " net ticks"}, ocnt, exp_net(k, add, mask));
    chk({tag, " R9 idle-cycle ticks"}, lowcnt, add ? ((1 << MW) >> k) : 0);
  endtask

  task automatic t_reset;
    do_reset;
    chk("R1 pend after reset", int'(pend), 0);
    set_range(0, WLEN);
    wait_gt(WLEN + 1);
    @(negedge clk);
    chk("R1 ticks in default window", ocnt, WLEN);
    chk("R1 suppressed strobes", dropcnt, 0);
    chk("R9 no idle tick by default", lowcnt, 0);
  endtask

  task automatic t_spread;
    do_reset;
    set_range(WLEN, WLEN);
    wait_gt(10);
    cfg_write(0, 0, 0, 2);
    wait_gt(m_hi + 1);
    @(negedge clk);
    chk("R7 drop count mask 2", dropcnt, 2);
    chk("R7 first drop position", drop0, 0);
    chk("R7 second drop position", drop1, WLEN / 2);
  endtask

  task automatic t_pending;
    do_reset;
    set_range(0, WLEN);
    wait_gt(10);
    cfg_write(0, 0, 0, 5);
    @(negedge clk);
    chk("R8 pend after write", int'(pend), 1);
    wait_gt(WLEN - 100);
    @(negedge clk);
    chk("R8 pend held mid-window", int'(pend), 1);
    wait_gt(WLEN + 1);
    @(negedge clk);
    chk("R8 old setting kept for window", ocnt, WLEN);
    chk("R8 pend cleared at boundary", int'(pend), 0);
    set_range(2 * WLEN, WLEN);
    wait_gt(3 * WLEN + 1);
    @(negedge clk);
    chk("R8 new setting applied", ocnt, WLEN - 5);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    run_case("R3 R5 mask 5", 0, 0, 0, 5);
    run_case("R3 R5 mask max", 0, 0, 0, (1 << MW) - 1);
    run_case("R4 R5 add mask 0", 0, 0, 1, 0);
    run_case("R4 R5 add mask max", 0, 0, 1, (1 << MW) - 1);
    t_spread;
    run_case("R2 R5 R6 16s add mask 7", 0, 1, 1, 7);
    run_case("R2 R6 16s add mask 6", 0, 1, 1, 6);
    run_case("R2 R6 8s mask 11", 1, 0, 0, 11);
    run_case("R2 8s over 16s mask 11", 1, 1, 0, 11);
    t_pending;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule